// File: doc/BRIEF.md
# Two-Wire Controlled Field Modulator

This block watches the SCL and SDA lines of a two-wire slave port. It waits for the control byte that follows a START. When that byte is one of the two modulator selectors, the block acknowledges it and then treats the bus as a raw bit stream. SCL becomes the bit clock and SDA carries one data bit per SCL period. No further byte framing or acknowledge slots occur. Each captured bit is line-coded onto a single damping-control output: 1 damps the coil and 0 leaves it undamped. The coding is either Manchester or Bi-phase, depending on the selector.

While the stream is active, normal memory access through the same port is held off. A STOP ends the stream and parks the output undamped. A fresh START, including a repeated START, ends it too and restarts control-byte reception. Control bytes that are not selectors get no acknowledge from this block and leave the output untouched.

Both bus lines pass through a synchronizer of SYNC_STAGES flops before any edge or condition is decoded. Every output is a registered value.

Top module: `modulator_bridge`

## Requirements
- R1: After synchronous reset, damp_o = 0, sda_low_o = 0, mod_active_o = 0 and eeprom_en_o = 1.
- R2: A control byte, sent MSB first, whose bits [7:5] = 110 and bits [2:0] = 111 is acknowledged. In the ninth clock, sda_low_o pulls SDA low during SCL high. The stream mode is entered at the falling SCL edge that ends that clock. Bit 3 is ignored.
- R3: Bit 4 of a selector byte chooses the coding: 1 selects Manchester and 0 selects Bi-phase.
- R4: Any other control byte gets no acknowledge. mod_active_o stays 0, eeprom_en_o stays 1 and damp_o stays 0 until the next START or STOP.
- R5: In Manchester coding, the SDA value sampled at a rising SCL edge is driven on damp_o while SCL is high. Its inverse is driven while SCL is low.
- R6: In Bi-phase coding, damp_o toggles at every rising SCL edge. It toggles again at the falling SCL edge only when the bit is 0. The level is 0 at stream entry.
- R7: In stream mode, bits flow without any acknowledge slot for as long as the master clocks. sda_low_o stays 0 throughout.
- R8: A STOP (SDA rising while SCL is high) ends stream mode. It sets damp_o = 0, mod_active_o = 0 and eeprom_en_o = 1.
- R9: eeprom_en_o is 0 from the acknowledge of a selector byte until the stream ends.
- R10: A START (SDA falling while SCL is high) during stream mode ends the stream with damp_o = 0. The next eight bits are taken as a new control byte.
- R11: damp_o follows an SCL edge at the (SYNC_STAGES+1)-th rising clk edge after the line changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Two-wire clock line |
| sda_i | input | 1 | Two-wire data line (bus value) |
| sda_low_o | output | 1 | 1 pulls SDA low (acknowledge) |
| damp_o | output | 1 | Damping control, 1 = coil damped |
| mod_active_o | output | 1 | Stream mode active |
| eeprom_en_o | output | 1 | 0 holds off normal memory access |

## Verification
An encoder level that is stuck or has inverted parity shows up in the first half of the next bit cell. It is seen as a damp_o value that differs from the one computed from the bits already sent. A frame state that is wrong shows up one SCL clock later, at the acknowledge clock or at the first cell. It appears as a missing or spurious pull on SDA, or as mod_active_o and eeprom_en_o disagreeing with the control byte. Every one of the 256 control bytes is swept, and selector bytes carry short streams. Long streams in each coding, a repeated START and a latency probe at clk resolution complete the coverage.

// File: rtl/modbr_pkg.sv
package modbr_pkg;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_CTRL,
    FR_ACK,
    FR_STREAM,
    FR_SKIP
  } frame_st_t;

  localparam int CTRL_BITS = 8;
  localparam int SEL_BIT   = 4;

  function automatic logic is_mod_ctrl(input logic [CTRL_BITS-1:0] b);
    return (b[7:5] == 3'b110) && (b[2:0] == 3'b111);
  endfunction

endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic scl_s, scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy[0] <= scl_i;
      sda_sy[0] <= sda_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        scl_sy[i] <= scl_sy[i-1];
        sda_sy[i] <= sda_sy[i-1];
      end
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s    = scl_sy[SYNC_STAGES-1];
  assign sda_s    = sda_sy[SYNC_STAGES-1];
  assign ev_rise  = scl_s & ~scl_p;
  assign ev_fall  = ~scl_s & scl_p;
  assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import modbr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sda_s,
  input  logic ev_rise,
  input  logic ev_fall,
  input  logic ev_start,
  input  logic ev_stop,
  output logic stream_on,
  output logic manch_sel,
  output logic ack_pull,
  output logic access_en
);

  localparam int CW = $clog2(CTRL_BITS);

  frame_st_t              st_q, st_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic [CTRL_BITS-1:0]   sh_q, sh_d;
  logic                   pull_q, pull_d;
  logic                   sel_q, sel_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    pull_d = pull_q;
    sel_d  = sel_q;
    if (ev_start) begin
      st_d   = FR_CTRL;
      cnt_d  = '0;
      pull_d = 1'b0;
    end else if (ev_stop) begin
      st_d   = FR_IDLE;
      pull_d = 1'b0;
    end else begin
      case (st_q)
        FR_CTRL: begin
          if (ev_rise) begin
            sh_d  = {sh_q[CTRL_BITS-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CW'(CTRL_BITS-1)) begin
              if (is_mod_ctrl(sh_d)) begin
                st_d  = FR_ACK;
                sel_d = sh_d[SEL_BIT];
              end else begin
                st_d = FR_SKIP;
              end
            end
          end
        end
        FR_ACK: begin
          if (ev_fall) begin
            if (!pull_q) begin
              pull_d = 1'b1;
            end else begin
              pull_d = 1'b0;
              st_d   = FR_STREAM;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      pull_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      pull_q <= pull_d;
      sel_q  <= sel_d;
    end
  end

  assign stream_on = (st_q == FR_STREAM);
  assign manch_sel = sel_q;
  assign ack_pull  = pull_q;
  assign access_en = !((st_q == FR_ACK) || (st_q == FR_STREAM));

  // R2: stream entry only at the end of a driven acknowledge slot
  assert_enter_after_ack_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q == FR_STREAM) |-> $past(pull_q));

endmodule

// File: rtl/line_encoder.sv
module line_encoder (
  input  logic clk,
  input  logic rst,
  input  logic stream_on,
  input  logic manch,
  input  logic ev_rise,
  input  logic ev_fall,
  input  logic ev_clear,
  input  logic sda_s,
  output logic damp
);

  logic out_q, bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      bit_q <= 1'b0;
    end else if (ev_clear || !stream_on) begin
      out_q <= 1'b0;
    end else if (ev_rise) begin
      bit_q <= sda_s;
      out_q <= manch ? sda_s : ~out_q;
    end else if (ev_fall) begin
      if (manch) out_q <= ~bit_q;
      else if (!bit_q) out_q <= ~out_q;
    end
  end

  assign damp = out_q;

  // R5: Manchester always changes level at mid-cell
  assert_manch_midcell_R5: assert property (@(posedge clk) disable iff (rst)
    (stream_on && manch && ev_fall) |=> (damp != $past(damp)));

  // R6: Bi-phase always changes level at a cell boundary
  assert_biphase_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    (stream_on && !manch && ev_rise) |=> (damp != $past(damp)));

  // R8: undamped whenever the stream is not running
  assert_idle_undamped_R8: assert property (@(posedge clk) disable iff (rst)
    !stream_on |-> !damp);

endmodule

// File: rtl/modulator_bridge.sv
module modulator_bridge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_low_o,
  output logic damp_o,
  output logic mod_active_o,
  output logic eeprom_en_o
);

  logic sda_s, ev_rise, ev_fall, ev_start, ev_stop;
  logic stream_on, manch_sel;

  bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop)
  );

  frame_ctrl u_frm (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .ev_rise   (ev_rise),
    .ev_fall   (ev_fall),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .stream_on (stream_on),
    .manch_sel (manch_sel),
    .ack_pull  (sda_low_o),
    .access_en (eeprom_en_o)
  );

  line_encoder u_enc (
    .clk       (clk),
    .rst       (rst),
    .stream_on (stream_on),
    .manch     (manch_sel),
    .ev_rise   (ev_rise),
    .ev_fall   (ev_fall),
    .ev_clear  (ev_start | ev_stop),
    .sda_s     (sda_s),
    .damp      (damp_o)
  );

  assign mod_active_o = stream_on;

  // R7: no acknowledge pull while streaming
  assert_no_ack_in_stream_R7: assert property (@(posedge clk) disable iff (rst)
    mod_active_o |-> !sda_low_o);

  // R9: acknowledging a selector already blocks memory access
  assert_ack_blocks_access_R9: assert property (@(posedge clk) disable iff (rst)
    sda_low_o |-> !eeprom_en_o);

endmodule

// File: tb/modulator_bridge_test.sv
module modulator_bridge_test;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int SYNC       = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_low_o, damp_o, mod_active_o, eeprom_en_o;
  logic sda_bus;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus = m_sda & ~sda_low_o;

  modulator_bridge #(.SYNC_STAGES(SYNC)) uut (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (m_scl),
    .sda_i        (sda_bus),
    .sda_low_o    (sda_low_o),
    .damp_o       (damp_o),
    .mod_active_o (mod_active_o),
    .eeprom_en_o  (eeprom_en_o)
  );

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n*Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic send_bit(input bit b);
    m_sda = b; wq();
    m_scl = 1'b1; wq(2);
    m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input bit [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic ack_clock(input int exp, input string tag);
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    check(sda_bus ? 0 : 1, exp, tag);
    wq();
    m_scl = 1'b0; wq();
  endtask

  // one streamed cell, both halves checked against the bench model
  task automatic mod_cell(input bit b, input bit manch, inout bit lvl);
    bit h1, h2;
    if (manch) begin
      h1 = b; h2 = ~b;
    end else begin
      lvl = ~lvl; h1 = lvl;
      if (!b) lvl = ~lvl;
      h2 = lvl;
    end
    m_sda = b; wq();
    m_scl = 1'b1; wq();
    check(damp_o, h1, manch ? "R5 manchester first half" : "R6 biphase first half");
    check(sda_low_o, 0, "R7 no ack pull in stream");
    wq();
    m_scl = 1'b0; wq();
    check(damp_o, h2, manch ? "R5 manchester second half" : "R6 biphase second half");
  endtask

  function automatic bit is_sel(input bit [7:0] c);
    return (c[7:5] == 3'b110) && (c[2:0] == 3'b111);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit lvl;
    bit [15:0] lfsr;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(damp_o, 0, "R1 reset damp");
    check(sda_low_o, 0, "R1 reset pull");
    check(mod_active_o, 0, "R1 reset active");
    check(eeprom_en_o, 1, "R1 reset access");

    // sweep of every control byte (R2, R3, R4, R8, R9)
    for (int c = 0; c < 256; c++) begin
      bit [7:0] cb;
      bit sel;
      bit [5:0] pat;
      cb  = 8'(c);
      sel = is_sel(cb);
      bus_start();
      send_byte(cb);
      ack_clock(sel ? 1 : 0, sel ? "R2 selector acknowledged" : "R4 other byte not acknowledged");
      if (sel) begin
        check(mod_active_o, 1, "R2 stream entered");
        check(eeprom_en_o, 0, "R9 access blocked in stream");
        lvl = 1'b0;
        pat = 6'((c * 37 + 11) & 63);
        for (int k = 0; k < 6; k++) mod_cell(pat[k], cb[4], lvl);
        check(eeprom_en_o, 0, "R9 access still blocked");
        bus_stop();
        check(damp_o, 0, "R8 stop undamped");
        check(mod_active_o, 0, "R8 stop leaves stream");
        check(eeprom_en_o, 1, "R8 stop restores access");
      end else begin
        check(mod_active_o, 0, "R4 no stream for other byte");
        for (int k = 0; k < 4; k++) begin
          m_sda = 1'(k & 1); wq();
          m_scl = 1'b1; wq();
          check(damp_o, 0, "R4 output untouched");
          check(eeprom_en_o, 1, "R4 access kept");
          wq();
          m_scl = 1'b0; wq();
        end
        bus_stop();
      end
    end

    // long streams in both codings (R3, R5, R6, R7)
    for (int m = 0; m < 2; m++) begin
      bus_start();
      send_byte(m == 1 ? 8'hDF : 8'hC7);
      ack_clock(1, "R3 coding selector acknowledged");
      lvl  = 1'b0;
      lfsr = 16'hACE1;
      for (int k = 0; k < 40; k++) begin
        mod_cell(lfsr[0], m == 1, lvl);
        lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      end
      check(mod_active_o, 1, "R7 stream of any length");
      bus_stop();
      check(damp_o, 0, "R8 stop after long stream");
    end

    // repeated START inside a stream (R10)
    bus_start();
    send_byte(8'hC7);
    ack_clock(1, "R10 setup selector");
    lvl = 1'b0;
    mod_cell(1'b1, 1'b0, lvl);
    mod_cell(1'b1, 1'b0, lvl);
    mod_cell(1'b0, 1'b0, lvl);
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    check(damp_o, 1, "R10 level before restart");
    m_sda = 1'b0; wq();
    check(damp_o, 0, "R10 restart undamped");
    check(mod_active_o, 0, "R10 restart leaves stream");
    m_scl = 1'b0; wq();
    send_byte(8'hD7);
    ack_clock(1, "R10 new control byte taken");
    check(mod_active_o, 1, "R10 new stream active");
    lvl = 1'b0;
    mod_cell(1'b0, 1'b1, lvl);
    bus_stop();

    // latency probe (R11)
    bus_start();
    send_byte(8'hD7);
    ack_clock(1, "R11 setup selector");
    m_sda = 1'b1; wq();
    @(negedge clk);
    m_scl = 1'b1;
    repeat (SYNC) @(negedge clk);
    check(damp_o, 0, "R11 not yet updated");
    @(negedge clk);
    check(damp_o, 1, "R11 updated after SYNC+1 edges");
    wq();
    m_scl = 1'b0; wq();
    bus_stop();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule